// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This combinational block forms the second operand of an ALU together with the carry value that the shifter hands to the flag logic. It has two modes. In register mode a 32-bit word is shifted or rotated by one of four kinds of operation. The amount comes either from a 5-bit field in the instruction or from the low byte of a second register. In constant mode an 8-bit value is zero-extended and rotated right by an even amount, twice a 4-bit field. Register reads and instruction decode sit outside the block.

An immediate amount of zero does not always mean "no shift". For logical-right and arithmetic-right it means a shift by the full word width. For rotate it means a one-bit rotate through the incoming carry. A register amount uses only its low byte. Amounts of the full width or more saturate in a way that depends on the operation kind.

Top module: `operand_shifter`

## Requirements
- R1: Shift kind code 2'b00 is a logical left shift. Zeros enter at bit 0, and carry-out is the last bit that leaves bit 31.
- R2: A left shift by zero, from either amount source, returns the operand unchanged, with carry-out equal to the incoming carry.
- R3: Shift kind code 2'b01 is a logical right shift. Zeros enter at bit 31, and carry-out is the last bit that leaves bit 0.
- R4: A logical right shift with an immediate amount of 0 acts as a shift by 32. The result is zero and carry-out equals operand bit 31.
- R5: Shift kind code 2'b10 is an arithmetic right shift, which fills with operand bit 31. With an immediate amount of 0 it acts as a shift by 32: every result bit and carry-out equal operand bit 31.
- R6: Shift kind code 2'b11 is a rotate right. Bits leaving bit 0 re-enter at bit 31, and carry-out is the last bit rotated (the new bit 31).
- R7: A rotate with an immediate amount of 0 is a one-bit rotate through carry. The old carry enters bit 31 and old bit 0 becomes carry-out.
- R8: A register-sourced amount uses only bits 7:0 of the amount register. An amount of 0 passes the operand through with carry-out equal to the incoming carry, for every kind.
- R9: A register amount of exactly 32 gives the following. Left shift: zero, carry = bit 0. Logical right: zero, carry = bit 31. Arithmetic right: all bits and carry = bit 31. Rotate: operand unchanged, carry = bit 31.
- R10: A register amount above 32 gives the following. Left and logical right: zero with carry 0. Arithmetic right: all bits and carry = bit 31. Rotate: rotation by the amount modulo 32, where a remainder of 0 behaves as 32.
- R11: In constant mode the result is the 8-bit constant, zero-extended and rotated right by 2 × the 4-bit rotate field. The operand word, shift kind and amount inputs have no effect.
- R12: In constant mode a rotate field of 0 gives carry-out equal to the incoming carry. Otherwise carry-out equals result bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cIn | input | 1 | Incoming carry flag |
| operand | input | 32 | Register word to shift |
| shiftKind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amtFromReg | input | 1 | 1: amount from amtReg, 0: amount from amtImm |
| amtImm | input | 5 | Immediate shift amount |
| amtReg | input | 32 | Register holding the shift amount (low byte used) |
| constMode | input | 1 | 1: rotated-constant mode |
| constByte | input | 8 | Constant for constant mode |
| constRot | input | 4 | Half the constant rotate amount |
| result | output | 32 | Shifted operand |
| cOut | output | 1 | Shifter carry-out |

## Verification
Directed patterns with a single set bit at the edges (bits 0 and 31) and alternating patterns separate the operation kinds. They also show which bit becomes the carry. Negative and positive operands separate sign fill from zero fill. Register amounts of 0, 1, 31, 32, 33, 64 and values with bits set above bit 7 exercise the saturation rules and the low-byte truncation. A random sweep compares the block against a bench model that moves one bit per step.

// File: rtl/operand_shifter_pkg.sv
package operand_shifter_pkg;

  parameter int unsigned SHAMT_W = 8;

  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shiftKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               useConst;  // source is the zero-extended constant
    logic               passThru;  // value unchanged, carry = cIn
    logic               rrx;       // rotate one through carry
    logic               zeroAll;   // result and carry zero
    shiftKind_e         kind;
    logic [SHAMT_W-1:0] amt;       // effective amount, 1..DATA_W when used
  } shiftCtrl_t;

endpackage

// File: rtl/shift_control.sv
module shift_control
  import operand_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROT_W  = 4
) (
  input  logic                       constMode,
  input  logic [1:0]                 shiftKind,
  input  logic                       amtFromReg,
  input  logic [$clog2(DATA_W)-1:0]  amtImm,
  input  logic [SHAMT_W-1:0]         amtRegLow,
  input  logic [ROT_W-1:0]           constRot,
  output shiftCtrl_t                 ctrl
);

  localparam int unsigned SH_W = $clog2(DATA_W);
  localparam logic [SHAMT_W-1:0] FULL = SHAMT_W'(DATA_W);

  logic [SHAMT_W-1:0] rawAmt;
  shiftKind_e         kindIn;

  assign rawAmt = amtFromReg ? amtRegLow : SHAMT_W'(amtImm);
  assign kindIn = shiftKind_e'(shiftKind);

  always_comb begin
    ctrl          = '0;
    ctrl.kind     = kindIn;
    ctrl.useConst = constMode;
    if (constMode) begin
      ctrl.kind = KIND_ROR;
      if (constRot == '0) ctrl.passThru = 1'b1;
      else                ctrl.amt      = SHAMT_W'({constRot, 1'b0});
    end else if (rawAmt == '0) begin
      if (amtFromReg || kindIn == KIND_LSL) ctrl.passThru = 1'b1;
      else if (kindIn == KIND_ROR)          ctrl.rrx      = 1'b1;
      else                                  ctrl.amt      = FULL;
    end else if (rawAmt <= FULL) begin
      ctrl.amt = rawAmt;
    end else begin
      unique case (kindIn)
        KIND_LSL, KIND_LSR: ctrl.zeroAll = 1'b1;
        KIND_ASR:           ctrl.amt     = FULL;
        default: begin
          if (rawAmt[SH_W-1:0] == '0) ctrl.amt = FULL;
          else                        ctrl.amt = SHAMT_W'(rawAmt[SH_W-1:0]);
        end
      endcase
    end
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import operand_shifter_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CONST_W = 8
) (
  input  shiftCtrl_t          ctrl,
  input  logic                cIn,
  input  logic [DATA_W-1:0]   operand,
  input  logic [CONST_W-1:0]  constByte,
  output logic [DATA_W-1:0]   result,
  output logic                cOut
);

  localparam int unsigned EXT_W = 2 * DATA_W + 1;

  logic [DATA_W-1:0] srcWord;
  logic [DATA_W-1:0] fillWord;
  logic [EXT_W-1:0]  leftExt;
  logic [EXT_W-1:0]  rightExt;
  logic [EXT_W-1:0]  rotExt;

  assign srcWord  = ctrl.useConst ? DATA_W'(constByte) : operand;
  assign fillWord = (ctrl.kind == KIND_ASR) ? {DATA_W{srcWord[DATA_W-1]}} : '0;

  // bit DATA_W of leftExt holds the last bit pushed out of the top
  assign leftExt  = {(DATA_W + 1)'(0), srcWord} << ctrl.amt;
  // bit 0 of the right-hand vectors holds the last bit pushed out of the bottom
  assign rightExt = {fillWord, srcWord, 1'b0} >> ctrl.amt;
  assign rotExt   = {srcWord, srcWord, 1'b0} >> ctrl.amt;

  always_comb begin
    if (ctrl.passThru) begin
      result = srcWord;
      cOut   = cIn;
    end else if (ctrl.zeroAll) begin
      result = '0;
      cOut   = 1'b0;
    end else if (ctrl.rrx) begin
      result = {cIn, srcWord[DATA_W-1:1]};
      cOut   = srcWord[0];
    end else begin
      unique case (ctrl.kind)
        KIND_LSL: begin
          result = leftExt[DATA_W-1:0];
          cOut   = leftExt[DATA_W];
        end
        KIND_ROR: begin
          result = rotExt[DATA_W:1];
          cOut   = rotExt[0];
        end
        default: begin
          result = rightExt[DATA_W:1];
          cOut   = rightExt[0];
        end
      endcase
    end
  end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import operand_shifter_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CONST_W = 8,
  parameter int unsigned ROT_W   = 4
) (
  input  logic                       cIn,
  input  logic [DATA_W-1:0]          operand,
  input  logic [1:0]                 shiftKind,
  input  logic                       amtFromReg,
  input  logic [$clog2(DATA_W)-1:0]  amtImm,
  input  logic [DATA_W-1:0]          amtReg,
  input  logic                       constMode,
  input  logic [CONST_W-1:0]         constByte,
  input  logic [ROT_W-1:0]           constRot,
  output logic [DATA_W-1:0]          result,
  output logic                       cOut
);

  shiftCtrl_t ctrl;

  shift_control #(.DATA_W(DATA_W), .ROT_W(ROT_W)) u_ctrl (
    .constMode  (constMode),
    .shiftKind  (shiftKind),
    .amtFromReg (amtFromReg),
    .amtImm     (amtImm),
    .amtRegLow  (amtReg[SHAMT_W-1:0]),
    .constRot   (constRot),
    .ctrl       (ctrl)
  );

  shift_datapath #(.DATA_W(DATA_W), .CONST_W(CONST_W)) u_dp (
    .ctrl      (ctrl),
    .cIn       (cIn),
    .operand   (operand),
    .constByte (constByte),
    .result    (result),
    .cOut      (cOut)
  );

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CONST_W = 8,
  parameter int unsigned ROT_W   = 4
) (
  input logic                       cIn,
  input logic [DATA_W-1:0]          operand,
  input logic [1:0]                 shiftKind,
  input logic                       amtFromReg,
  input logic [$clog2(DATA_W)-1:0]  amtImm,
  input logic [DATA_W-1:0]          amtReg,
  input logic                       constMode,
  input logic [CONST_W-1:0]         constByte,
  input logic [ROT_W-1:0]           constRot,
  input logic [DATA_W-1:0]          result,
  input logic                       cOut
);

  logic known;
  assign known = !$isunknown({cIn, operand, shiftKind, amtFromReg, amtImm,
                              amtReg, constMode, constByte, constRot, result, cOut});

  always_comb begin
    if (known) begin
      if (!constMode && amtFromReg && amtReg[7:0] == 8'd0)
        p_regzero_pass_r8: assert (result == operand && cOut == cIn);
      if (!constMode && shiftKind == 2'b00 && amtImm != '0 && !amtFromReg)
        p_lsl_zero_fill_r1: assert (result[0] == 1'b0);
      if (!constMode && shiftKind == 2'b10)
        p_asr_sign_r5: assert (result[DATA_W-1] == operand[DATA_W-1]);
      if (!constMode && shiftKind == 2'b11 && (amtFromReg || amtImm != '0))
        p_ror_ones_r6: assert ($countones(result) == $countones(operand));
      if (!constMode && amtFromReg && shiftKind[1] == 1'b0 && amtReg[7:0] > 8'(DATA_W))
        p_over_zero_r10: assert (result == '0 && !cOut);
      if (constMode)
        p_const_ones_r11: assert ($countones(result) == $countones(constByte));
      if (constMode && constRot != '0)
        p_const_carry_r12: assert (cOut == result[DATA_W-1]);
    end
  end

endmodule

bind operand_shifter operand_shifter_chk #(
  .DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W)
) u_chk (
  .cIn(cIn), .operand(operand), .shiftKind(shiftKind), .amtFromReg(amtFromReg),
  .amtImm(amtImm), .amtReg(amtReg), .constMode(constMode), .constByte(constByte),
  .constRot(constRot), .result(result), .cOut(cOut)
);

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cIn;
  logic [31:0] operand;
  logic [1:0]  shiftKind;
  logic        amtFromReg;
  logic [4:0]  amtImm;
  logic [31:0] amtReg;
  logic        constMode;
  logic [7:0]  constByte;
  logic [3:0]  constRot;
  logic [31:0] result;
  logic        cOut;

  int vecCount  = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  operand_shifter u_dut (
    .cIn(cIn), .operand(operand), .shiftKind(shiftKind), .amtFromReg(amtFromReg),
    .amtImm(amtImm), .amtReg(amtReg), .constMode(constMode), .constByte(constByte),
    .constRot(constRot), .result(result), .cOut(cOut)
  );

  // one-bit-per-step model built from the requirements; returns {carry, value}
  function automatic logic [32:0] refModel(input logic cm, input logic [1:0] k,
      input logic fr, input logic [4:0] ai, input logic [31:0] ar,
      input logic [31:0] op, input logic [7:0] cb, input logic [3:0] cr,
      input logic ci);
    logic [31:0] v;
    logic        c;
    int          n;
    c = ci;
    if (cm) begin
      v = {24'd0, cb};
      for (int i = 0; i < 2 * cr; i++) begin c = v[0]; v = {v[0], v[31:1]}; end
      return {c, v};
    end
    v = op;
    n = fr ? int'(ar[7:0]) : int'(ai);
    if (!fr && n == 0) begin
      if (k == 2'b01 || k == 2'b10) n = 32;
      if (k == 2'b11) return {v[0], ci, v[31:1]};
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'b00:   begin c = v[31]; v = {v[30:0], 1'b0}; end
        2'b01:   begin c = v[0];  v = {1'b0, v[31:1]}; end
        2'b10:   begin c = v[0];  v = {v[31], v[31:1]}; end
        default: begin c = v[0];  v = {v[0], v[31:1]}; end
      endcase
    end
    return {c, v};
  endfunction

  task automatic checkOut(input string req, input logic [31:0] expV, input logic expC);
    @(posedge clk);
    #5;
    vecCount++;
    if (result !== expV || cOut !== expC) begin
      failCount++;
      $display("FAIL %s: got result=%h c=%b, expected result=%h c=%b",
               req, result, cOut, expV, expC);
    end
  endtask

  task automatic applyReg(input string req, input logic [1:0] k, input logic fr,
      input logic [4:0] ai, input logic [31:0] ar, input logic [31:0] op, input logic ci);
    logic [32:0] e;
    constMode = 1'b0; shiftKind = k; amtFromReg = fr; amtImm = ai; amtReg = ar;
    operand = op; cIn = ci;
    e = refModel(1'b0, k, fr, ai, ar, op, constByte, constRot, ci);
    checkOut(req, e[31:0], e[32]);
  endtask

  task automatic applyConst(input string req, input logic [7:0] cb, input logic [3:0] cr,
      input logic ci, input logic [31:0] op, input logic [1:0] k);
    logic [32:0] e;
    constMode = 1'b1; constByte = cb; constRot = cr; cIn = ci; operand = op;
    shiftKind = k; amtFromReg = 1'b1; amtReg = 32'h5;
    e = refModel(1'b1, k, 1'b1, amtImm, amtReg, op, cb, cr, ci);
    checkOut(req, e[31:0], e[32]);
  endtask

  task automatic tReset();
    cIn = 0; operand = 0; shiftKind = 0; amtFromReg = 0; amtImm = 0; amtReg = 0;
    constMode = 0; constByte = 0; constRot = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    checkOut("R2 idle", 32'h0, 1'b0);
  endtask

  task automatic tLeft();
    applyReg("R1", 2'b00, 0, 5'd1, 0, 32'h8000_0001, 0);
    checkOut("R1 fixed", 32'h0000_0002, 1'b1);
    applyReg("R1", 2'b00, 0, 5'd31, 0, 32'h0000_0003, 0);
    applyReg("R1", 2'b00, 1, 0, 32'd4, 32'hF000_000F, 0);
  endtask

  task automatic tZero();
    applyReg("R2", 2'b00, 0, 5'd0, 0, 32'hDEAD_BEEF, 1);
    checkOut("R2 fixed", 32'hDEAD_BEEF, 1'b1);
    applyReg("R2", 2'b00, 1, 5'd7, 32'h0, 32'h1234_5678, 0);
    for (int k = 0; k < 4; k++)
      applyReg("R8", 2'(k), 1, 5'd3, 32'hFFFF_FF00, 32'h8765_4321, 1);
  endtask

  task automatic tRight();
    applyReg("R3", 2'b01, 0, 5'd4, 0, 32'h8000_0018, 1);
    applyReg("R3", 2'b01, 1, 0, 32'd1, 32'h0000_0001, 0);
    applyReg("R4", 2'b01, 0, 5'd0, 0, 32'h8000_0000, 0);
    checkOut("R4 fixed", 32'h0, 1'b1);
    applyReg("R5", 2'b10, 0, 5'd3, 0, 32'h8000_0010, 0);
    applyReg("R5", 2'b10, 0, 5'd0, 0, 32'h8000_0000, 0);
    checkOut("R5 fixed", 32'hFFFF_FFFF, 1'b1);
    applyReg("R5", 2'b10, 0, 5'd0, 0, 32'h7FFF_FFFF, 1);
  endtask

  task automatic tRotate();
    applyReg("R6", 2'b11, 0, 5'd4, 0, 32'h0000_000F, 0);
    checkOut("R6 fixed", 32'hF000_0000, 1'b1);
    applyReg("R6", 2'b11, 1, 0, 32'd31, 32'h8000_0001, 0);
    applyReg("R7", 2'b11, 0, 5'd0, 0, 32'h0000_0001, 0);
    checkOut("R7 fixed", 32'h0000_0000, 1'b1);
    applyReg("R7", 2'b11, 0, 5'd0, 0, 32'h0000_0002, 1);
  endtask

  task automatic tWide();
    for (int k = 0; k < 4; k++) begin
      applyReg("R9", 2'(k), 1, 0, 32'd32, 32'h8000_0001, 0);
      applyReg("R9", 2'(k), 1, 0, 32'd32, 32'h7FFF_FFFE, 1);
      applyReg("R10", 2'(k), 1, 0, 32'd33, 32'hC000_0003, 1);
      applyReg("R10", 2'(k), 1, 0, 32'd64, 32'h8000_0001, 0);
      applyReg("R10", 2'(k), 1, 0, 32'd255, 32'hA5A5_5A5A, 0);
    end
    applyReg("R8", 2'b01, 1, 0, 32'h0000_0121, 32'hFFFF_FFFF, 1);
  endtask

  task automatic tConst();
    applyConst("R11", 8'hFF, 4'd4, 0, 32'h1234_5678, 2'b00);
    checkOut("R11 fixed", 32'hFF00_0000, 1'b1);
    applyConst("R11", 8'h81, 4'd1, 0, 32'hFFFF_FFFF, 2'b01);
    applyConst("R12", 8'h7F, 4'd0, 1, 32'h0, 2'b10);
    checkOut("R12 fixed", 32'h0000_007F, 1'b1);
    applyConst("R12", 8'h02, 4'd1, 1, 32'h0, 2'b11);
    checkOut("R12 fixed", 32'h8000_0000, 1'b1);
    applyConst("R12", 8'h04, 4'd1, 1, 32'h0, 2'b11);
  endtask

  task automatic tSweep();
    for (int i = 0; i < 400; i++) begin
      if (i % 5 == 0)
        applyConst("R11 sweep", 8'($urandom), 4'($urandom), 1'($urandom),
                   $urandom, 2'($urandom));
      else
        applyReg("R10 sweep", 2'($urandom), 1'($urandom), 5'($urandom),
                 (i % 2 == 0) ? 32'($urandom % 70) : $urandom, $urandom, 1'($urandom));
    end
  endtask

  initial begin
    #(20 * 200000);
    failCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    tReset();
    tLeft();
    tZero();
    tRight();
    tRotate();
    tWide();
    tConst();
    tSweep();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule